// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

The block is a configurable AND-OR array. Dedicated inputs and feedback signals each provide a true and a complemented literal line. Each product term ANDs whichever literal lines it is connected to. Fixed groups of product terms are then ORed into one sum per output.

Connectivity lives in a configuration store that holds one bit per term/literal intersection. A host controls the store with three operations:
- erase the whole store in one cycle;
- close single intersections, one write per cycle;
- load a per-output select vector.

Each output owns one auxiliary term. That term is always exported on its own. It is also folded into the output's sum when the output's select bit is set; otherwise it serves as a raw enable for logic outside the block. Apart from the store, the whole path is combinational.

Top module: `sop_array`

## Requirements
- R1: While rst_ni is low, and straight after reset, every intersection is open and every select bit is 0. Hence every bit of sum_o and aux_o is 1.
- R2: Literal index 2*s carries signal s and literal 2*s+1 carries its complement. Signals 0..N_IN-1 are data_i bits 0..N_IN-1, and signals N_IN.. are fb_i bits 0...
- R3: A product term is the AND of exactly the literal lines whose intersection bit is set. Open intersections have no effect on the term.
- R4: A product term with every intersection open evaluates to 1 for every input pattern.
- R5: A product term connected to both the true and the complement literal of one signal is 0 for every input pattern.
- R6: Output o owns terms o*(TERMS_PER_SUM+1) through o*(TERMS_PER_SUM+1)+TERMS_PER_SUM. The last of these is the auxiliary term. sum_o[o] is the OR of the other terms, ORed with the auxiliary term only when select bit o is 1.
- R7: aux_o[o] is the auxiliary term of output o, whatever the select bit.
- R8: When cfg_wr_i is high at a rising clock edge, that edge closes exactly the intersection given by cfg_term_i/cfg_lit_i. Before that edge the outputs do not change. A write whose literal index is not below the literal count is ignored.
- R9: cfg_erase_i at a rising edge opens every intersection and clears every select bit. If a write or a select load arrives in the same cycle, the erase wins.
- R10: cfg_sel_we_i at a rising edge loads cfg_sel_i as the select vector. The new vector takes effect only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration store |
| rst_ni | input | 1 | Asynchronous active-low reset (opens all intersections) |
| data_i | input | N_IN | Dedicated input signals |
| fb_i | input | N_FB | Feedback signals |
| cfg_erase_i | input | 1 | Bulk erase strobe |
| cfg_wr_i | input | 1 | Close-one-intersection strobe |
| cfg_term_i | input | clog2(N_TERM) | Product term index of the write |
| cfg_lit_i | input | clog2(N_LIT) | Literal index of the write |
| cfg_sel_we_i | input | 1 | Select vector load strobe |
| cfg_sel_i | input | N_OUT | Select vector: 1 folds the auxiliary term into the sum |
| sum_o | output | N_OUT | OR sums |
| aux_o | output | N_OUT | Auxiliary product terms |

## Verification
The bench builds the array with 3 dedicated inputs, 2 feedback signals, 2 outputs and 3 grouped terms per sum. That gives 5 signals, 10 literals and 8 product terms. Every configuration can therefore be checked against all 32 input patterns, and single-signal, contradictory and fully open terms can each be placed on chosen term positions. The small store also keeps write timing, out-of-range literal writes and erase-versus-write collisions cheap to provoke, with the whole array state visible at the outputs.

// File: rtl/sop_pkg.sv
package sop_pkg;
  // term index of grouped term k of output o
  function automatic int sum_term(int o, int k, int tps);
    return o * (tps + 1) + k;
  endfunction

  // term index of the auxiliary term of output o
  function automatic int aux_term(int o, int tps);
    return o * (tps + 1) + tps;
  endfunction
endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
  parameter int N_TERM = 64,
  parameter int N_LIT  = 32,
  parameter int N_OUT  = 8,
  parameter int TW     = 6,
  parameter int LW     = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          erase_i,
  input  logic                          wr_i,
  input  logic [TW-1:0]                 term_i,
  input  logic [LW-1:0]                 lit_i,
  input  logic                          sel_we_i,
  input  logic [N_OUT-1:0]              sel_i,
  output logic [N_TERM-1:0][N_LIT-1:0]  conn_o,
  output logic [N_OUT-1:0]              sel_o
);
  logic [N_TERM-1:0][N_LIT-1:0] conn_q;
  logic [N_OUT-1:0]             sel_q;
  logic                         wr_ok;

  assign wr_ok = wr_i && (int'(term_i) < N_TERM) && (int'(lit_i) < N_LIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q <= '0;
    end else if (erase_i) begin
      conn_q <= '0;
    end else if (wr_ok) begin
      conn_q[term_i][lit_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
    end else if (erase_i) begin
      sel_q <= '0;
    end else if (sel_we_i) begin
      sel_q <= sel_i;
    end
  end

  assign conn_o = conn_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/sop_literals.sv
module sop_literals #(
  parameter int N_IN  = 8,
  parameter int N_FB  = 8,
  localparam int N_SIG = N_IN + N_FB,
  localparam int N_LIT = 2 * N_SIG
) (
  input  logic [N_IN-1:0]  data_i,
  input  logic [N_FB-1:0]  fb_i,
  output logic [N_LIT-1:0] lit_o
);
  logic [N_SIG-1:0] sig;
  assign sig = {fb_i, data_i};

  for (genvar s = 0; s < N_SIG; s++) begin : g_sig
    assign lit_o[2*s]   = sig[s];
    assign lit_o[2*s+1] = ~sig[s];
  end
endmodule

// File: rtl/sop_term.sv
module sop_term #(
  parameter int N_LIT = 32
) (
  input  logic [N_LIT-1:0] conn_i,
  input  logic [N_LIT-1:0] lit_i,
  output logic             term_o
);
  // open intersection passes 1; all-open term is therefore TRUE
  assign term_o = &(~conn_i | lit_i);
endmodule

// File: rtl/sop_array.sv
module sop_array #(
  parameter int N_IN          = 8,
  parameter int N_FB          = 8,
  parameter int N_OUT         = 8,
  parameter int TERMS_PER_SUM = 7,
  localparam int N_SIG  = N_IN + N_FB,
  localparam int N_LIT  = 2 * N_SIG,
  localparam int TPO    = TERMS_PER_SUM + 1,
  localparam int N_TERM = N_OUT * TPO,
  localparam int TW     = $clog2(N_TERM),
  localparam int LW     = $clog2(N_LIT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   data_i,
  input  logic [N_FB-1:0]   fb_i,
  input  logic              cfg_erase_i,
  input  logic              cfg_wr_i,
  input  logic [TW-1:0]     cfg_term_i,
  input  logic [LW-1:0]     cfg_lit_i,
  input  logic              cfg_sel_we_i,
  input  logic [N_OUT-1:0]  cfg_sel_i,
  output logic [N_OUT-1:0]  sum_o,
  output logic [N_OUT-1:0]  aux_o
);
  import sop_pkg::*;

  logic [N_TERM-1:0][N_LIT-1:0] conn_w;
  logic [N_OUT-1:0]             sel_w;
  logic [N_LIT-1:0]             lit_w;
  logic [N_TERM-1:0]            term_w;

  sop_cfg_store #(
    .N_TERM(N_TERM), .N_LIT(N_LIT), .N_OUT(N_OUT), .TW(TW), .LW(LW)
  ) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .erase_i  (cfg_erase_i),
    .wr_i     (cfg_wr_i),
    .term_i   (cfg_term_i),
    .lit_i    (cfg_lit_i),
    .sel_we_i (cfg_sel_we_i),
    .sel_i    (cfg_sel_i),
    .conn_o   (conn_w),
    .sel_o    (sel_w)
  );

  sop_literals #(.N_IN(N_IN), .N_FB(N_FB)) i_lit (
    .data_i (data_i),
    .fb_i   (fb_i),
    .lit_o  (lit_w)
  );

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    sop_term #(.N_LIT(N_LIT)) i_term (
      .conn_i (conn_w[t]),
      .lit_i  (lit_w),
      .term_o (term_w[t])
    );
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [TERMS_PER_SUM-1:0] grp;
    logic                     aux;
    assign grp      = term_w[sum_term(o, 0, TERMS_PER_SUM) +: TERMS_PER_SUM];
    assign aux      = term_w[aux_term(o, TERMS_PER_SUM)];
    assign sum_o[o] = (|grp) | (sel_w[o] & aux);
    assign aux_o[o] = aux;
  end
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
  parameter int N_OUT         = 8,
  parameter int TERMS_PER_SUM = 7,
  parameter int N_TERM        = 64,
  parameter int N_LIT         = 32,
  parameter int TW            = 6,
  parameter int LW            = 5
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         cfg_erase_i,
  input logic                         cfg_wr_i,
  input logic [TW-1:0]                cfg_term_i,
  input logic [LW-1:0]                cfg_lit_i,
  input logic                         cfg_sel_we_i,
  input logic [N_OUT-1:0]             cfg_sel_i,
  input logic [N_OUT-1:0]             sum_o,
  input logic [N_OUT-1:0]             aux_o,
  input logic [N_TERM-1:0][N_LIT-1:0] conn_w,
  input logic [N_OUT-1:0]             sel_w
);
  import sop_pkg::*;

  logic          pend_q;
  logic [TW-1:0] t_q;
  logic [LW-1:0] l_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      t_q    <= '0;
      l_q    <= '0;
    end else begin
      pend_q <= cfg_wr_i && !cfg_erase_i &&
                (int'(cfg_term_i) < N_TERM) && (int'(cfg_lit_i) < N_LIT);
      t_q    <= cfg_term_i;
      l_q    <= cfg_lit_i;
    end
  end

  p_reset_open_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (sum_o == '1 && aux_o == '1));

  p_write_closes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> conn_w[t_q][l_q]);

  p_erase_all_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_erase_i |=> (sel_w == '0 && aux_o == '1 && sum_o == '1));

  p_sel_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_sel_we_i && !cfg_erase_i) |=> (sel_w == $past(cfg_sel_i)));

  p_aux_folded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_w & aux_o & ~sum_o) == '0);

  for (genvar o = 0; o < N_OUT; o++) begin : g_chk
    p_open_true_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conn_w[aux_term(o, TERMS_PER_SUM)] == '0) |-> aux_o[o]);
  end
endmodule

bind sop_array sop_array_chk #(
  .N_OUT(N_OUT), .TERMS_PER_SUM(TERMS_PER_SUM), .N_TERM(N_TERM),
  .N_LIT(N_LIT), .TW(TW), .LW(LW)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_erase_i  (cfg_erase_i),
  .cfg_wr_i     (cfg_wr_i),
  .cfg_term_i   (cfg_term_i),
  .cfg_lit_i    (cfg_lit_i),
  .cfg_sel_we_i (cfg_sel_we_i),
  .cfg_sel_i    (cfg_sel_i),
  .sum_o        (sum_o),
  .aux_o        (aux_o),
  .conn_w       (conn_w),
  .sel_w        (sel_w)
);

// File: tb/test_sop_array.sv
module test_sop_array;
  localparam int N_IN   = 3;
  localparam int N_FB   = 2;
  localparam int N_OUT  = 2;
  localparam int TPS    = 3;
  localparam int TPO    = TPS + 1;
  localparam int N_SIG  = N_IN + N_FB;
  localparam int N_LIT  = 2 * N_SIG;
  localparam int N_TERM = N_OUT * TPO;
  localparam int TW     = $clog2(N_TERM);
  localparam int LW     = $clog2(N_LIT);

  logic             clk = 1'b0;
  logic             rst_n = 1'b1;
  logic [N_IN-1:0]  data = '0;
  logic [N_FB-1:0]  fb = '0;
  logic             erase = 1'b0;
  logic             wr = 1'b0;
  logic [TW-1:0]    term = '0;
  logic [LW-1:0]    lit = '0;
  logic             sel_we = 1'b0;
  logic [N_OUT-1:0] sel = '0;
  logic [N_OUT-1:0] sum, aux;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  mdl [N_TERM][N_LIT];
  bit  [N_OUT-1:0] msel = '0;
  logic [31:0] lf = 32'hACE1_1234;

  always #10 clk = ~clk;

  sop_array #(.N_IN(N_IN), .N_FB(N_FB), .N_OUT(N_OUT), .TERMS_PER_SUM(TPS)) i_sop_array (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .fb_i(fb),
    .cfg_erase_i(erase), .cfg_wr_i(wr), .cfg_term_i(term), .cfg_lit_i(lit),
    .cfg_sel_we_i(sel_we), .cfg_sel_i(sel), .sum_o(sum), .aux_o(aux)
  );

  task automatic check(string req, logic [N_OUT-1:0] act, logic [N_OUT-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_term(int t, logic [N_SIG-1:0] pat);
    for (int l = 0; l < N_LIT; l++)
      if (mdl[t][l] && ((pat[l/2] ^ l[0]) == 1'b0)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [N_OUT-1:0] exp_aux(logic [N_SIG-1:0] pat);
    logic [N_OUT-1:0] r;
    for (int o = 0; o < N_OUT; o++) r[o] = exp_term(o*TPO + TPS, pat);
    return r;
  endfunction

  function automatic logic [N_OUT-1:0] exp_sum(logic [N_SIG-1:0] pat);
    logic [N_OUT-1:0] r;
    for (int o = 0; o < N_OUT; o++) begin
      r[o] = msel[o] & exp_term(o*TPO + TPS, pat);
      for (int k = 0; k < TPS; k++) r[o] |= exp_term(o*TPO + k, pat);
    end
    return r;
  endfunction

  task automatic cfg_write(int t, int l);
    @(negedge clk);
    wr = 1'b1; term = TW'(t); lit = LW'(l);
    @(negedge clk);
    wr = 1'b0;
    if (t < N_TERM && l < N_LIT) mdl[t][l] = 1'b1;
  endtask

  task automatic cfg_erase();
    @(negedge clk);
    erase = 1'b1;
    @(negedge clk);
    erase = 1'b0;
    for (int t = 0; t < N_TERM; t++)
      for (int l = 0; l < N_LIT; l++) mdl[t][l] = 1'b0;
    msel = '0;
  endtask

  task automatic cfg_sel(logic [N_OUT-1:0] v);
    @(negedge clk);
    sel_we = 1'b1; sel = v;
    @(negedge clk);
    sel_we = 1'b0;
    msel = v;
  endtask

  task automatic sweep(string req);
    for (int p = 0; p < (1 << N_SIG); p++) begin
      @(negedge clk);
      {fb, data} = N_SIG'(p);
      #2;
      check({req, " sum"}, sum, exp_sum(N_SIG'(p)));
      check({req, " aux"}, aux, exp_aux(N_SIG'(p)));
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    // R1: reset state
    #3;
    check("R1 reset sum", sum, '1);
    check("R1 reset aux", aux, '1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    sweep("R1/R4 all open");

    // R5: contradictory literals on aux term 3
    cfg_write(3, 0);
    cfg_write(3, 1);
    sweep("R5 contradiction");

    // R2: single literal per aux term, each signal and polarity
    for (int s = 0; s < N_SIG; s++) begin
      cfg_erase();
      cfg_write(3, 2*s + 1);
      cfg_write(7, 2*s);
      sweep("R2 literal map");
    end

    // R3/R6/R7: pseudo-random configurations with every select value
    for (int c = 0; c < 4; c++) begin
      cfg_erase();
      for (int t = 0; t < N_TERM; t++)
        for (int s = 0; s < N_SIG; s++) begin
          lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
          if (lf[1:0] == 2'd1) cfg_write(t, 2*s);
          else if (lf[1:0] == 2'd2) cfg_write(t, 2*s + 1);
        end
      cfg_sel(N_OUT'(c));
      sweep("R3/R6/R7 random");
    end

    // R8: write timing
    cfg_erase();
    @(negedge clk);
    {fb, data} = N_SIG'(1);
    wr = 1'b1; term = TW'(3); lit = LW'(1);
    #2;
    check("R8 before edge aux", aux, 2'b11);
    @(posedge clk);
    #2;
    check("R8 after edge aux", aux, 2'b10);
    check("R8 after edge sum", sum, 2'b11);
    @(negedge clk);
    wr = 1'b0;
    mdl[3][1] = 1'b1;
    // R8: out-of-range literal index ignored
    cfg_write(7, N_LIT + 2);
    sweep("R8 range");

    // R9: erase clears select bits; erase wins over write
    cfg_sel(2'b11);
    cfg_erase();
    for (int o = 0; o < N_OUT; o++)
      for (int k = 0; k < TPS; k++) begin
        cfg_write(o*TPO + k, 0);
        cfg_write(o*TPO + k, 1);
      end
    sweep("R9 select cleared");
    @(negedge clk);
    erase = 1'b1; wr = 1'b1; term = TW'(7); lit = LW'(0);
    sel_we = 1'b1; sel = 2'b11;
    @(negedge clk);
    erase = 1'b0; wr = 1'b0; sel_we = 1'b0;
    for (int t = 0; t < N_TERM; t++)
      for (int l = 0; l < N_LIT; l++) mdl[t][l] = 1'b0;
    msel = '0;
    sweep("R9 erase wins");

    // R10: select load timing
    for (int o = 0; o < N_OUT; o++)
      for (int k = 0; k < TPS; k++) begin
        cfg_write(o*TPO + k, 2);
        cfg_write(o*TPO + k, 3);
      end
    cfg_sel(2'b01);
    sweep("R10 select 01");
    @(negedge clk);
    sel_we = 1'b1; sel = 2'b10;
    #2;
    check("R10 before edge", sum, 2'b01);
    @(posedge clk);
    #2;
    check("R10 after edge", sum, 2'b10);
    @(negedge clk);
    sel_we = 1'b0;
    msel = 2'b10;
    sweep("R10 select 10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule